// File: doc/BRIEF.md
# Seeded Symbol Scrambler with Self-Locking Descrambler

This block whitens a 5-bit coded symbol stream before it reaches the line and removes the same whitening on the receive side. A free-running 11-bit linear feedback shift register produces five keystream bits per symbol clock, and those bits are XORed onto the transmit symbol. The receive side runs a second register of the same shape. It brings that register into step with the far end by assuming that the link is idle. The idle symbol is all ones, so each received symbol XORed with ones gives back the keystream. The receiver declares lock after a run of consistent predictions.

The transmit register is loaded from the port's 5-bit address while reset is high, so ports that share a board start at different points of the sequence. Three things must all agree before whitening is applied: a strap input captured at the cycle reset rises, a configuration bit held inside the block, and the speed and line-mode inputs. When any of them says no, both directions pass symbols through with the same single register stage of delay.

Top module: `seeded_scrambler`

## Requirements
- R1: While `rst` is high the transmit generator state (11 bits, bit 10 the oldest) is loaded with `{6'b111111, phy_addr}`, so it is never all-zero.
- R2: Each symbol clock the generator makes 5 bits in turn. Each bit is `s[10]^s[8]`, and it is shifted into `s[0]`. The first bit made is XORed onto symbol bit 4 and the last onto bit 0. The generator advances every cycle out of reset, and `tx_sym_out` is registered one cycle after `tx_sym_in`.
- R3: `strap_scr` is captured only in the cycle where `rst` goes from low to high. Later changes of the pin, during reset or after it, have no effect until the next reset rising edge.
- R4: The configuration enable bit is 1 after reset. A cycle with `cfg_we` high loads it from `cfg_wdata`.
- R5: Whitening is active only when the captured strap, the configuration bit, `link_100` and `line_mlt3` are all high and `force_10` is low. Otherwise `tx_sym_out` and `rx_sym_out` equal their inputs one cycle later.
- R6: While unlocked, the receiver shifts `rx_sym_in ^ 5'b11111` into its own generator. It raises `rx_lock` after LOCK_RUN consecutive symbols in which that value equals the keystream predicted from a non-zero state.
- R7: While locked, `rx_sym_out` is `rx_sym_in` XORed with the receiver's free-running keystream, one cycle later. A transmit stream looped back to the receive input is therefore restored exactly.
- R8: While locked, LOCK_TIMEOUT consecutive descrambled symbols that are not all ones drop `rx_lock`. A single idle symbol restarts that count.
- R9: During reset, `tx_sym_out`, `rx_sym_out` and `rx_lock` are 0.
- R10: Whenever whitening is disabled, `rx_lock` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | 5 | Port address, used as the generator seed |
| strap_scr | input | 1 | Board strap, captured as reset rises |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | New value of the enable bit |
| link_100 | input | 1 | High when the port runs at 100 Mb/s |
| force_10 | input | 1 | High when the port is forced to 10 Mb/s |
| line_mlt3 | input | 1 | High in the three-level copper line mode |
| tx_sym_in | input | 5 | Coded transmit symbol |
| tx_sym_out | output | 5 | Whitened transmit symbol |
| rx_sym_in | input | 5 | Received whitened symbol |
| rx_sym_out | output | 5 | Restored receive symbol |
| rx_lock | output | 1 | Descrambler locked |

## Verification
The transmit output is compared against an independent model of the generator for two different address seeds. The stimulus includes idle, all-zero, counting and alternating symbols, so a wrong seed, wrong tap or wrong bit order shows up as a mismatch within a few symbols. The transmit output is looped back to the receive input to show lock acquisition on idle and exact recovery of data. Runs of non-idle symbols with one idle in the middle tell the timeout reset apart from the timeout expiry. Each disable source (strap, configuration bit, speed, forced speed, line mode) is toggled on its own with independent receive data, which shows that both paths fall back to a plain one-cycle delay.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int SYM_W  = 5;
    localparam int LFSR_W = 11;
    localparam int ADDR_W = 5;
    localparam int TAP_HI = 10;
    localparam int TAP_LO = 8;

    localparam logic [SYM_W-1:0] IDLE_SYM = '1;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        lfsr_t state;
        sym_t  ks;
    } lfsr_step_t;

    typedef enum logic {
        RX_HUNT   = 1'b0,
        RX_LOCKED = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic strap_ok;
        logic cfg_ok;
        logic speed_ok;
    } en_vec_t;

    // Advance one symbol: SYM_W bits, first bit lands on the symbol MSB.
    function automatic lfsr_step_t lfsr_advance(input lfsr_t s);
        lfsr_step_t r;
        lfsr_t      cur;
        logic       b;
        cur = s;
        r.ks = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            b       = cur[TAP_HI] ^ cur[TAP_LO];
            r.ks[i] = b;
            cur     = {cur[LFSR_W-2:0], b};
        end
        r.state = cur;
        return r;
    endfunction

    // Load recovered keystream bits into the state, MSB first.
    function automatic lfsr_t lfsr_shift_in(input lfsr_t s, input sym_t k);
        lfsr_t cur;
        cur = s;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            cur = {cur[LFSR_W-2:0], k[i]};
        end
        return cur;
    endfunction

    function automatic lfsr_t seed_from_addr(input addr_t a);
        lfsr_t r;
        r = '1;
        r[ADDR_W-1:0] = a;
        return r;
    endfunction

endpackage

// File: rtl/scr_en_ctrl.sv
module scr_en_ctrl
    import scr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strap_in,
    input  logic cfg_we,
    input  logic cfg_wdata,
    input  logic link_100,
    input  logic force_10,
    input  logic line_mlt3,
    output logic scr_en
);

    logic    rst_d;
    logic    strap_q;
    logic    cfg_q;
    en_vec_t gate;

    // Strap is taken only on the low-to-high transition of reset.
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst && !rst_d) begin
            strap_q <= strap_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= 1'b1;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    always_comb begin
        gate.strap_ok = strap_q;
        gate.cfg_ok   = cfg_q;
        gate.speed_ok = link_100 && !force_10 && line_mlt3;
        scr_en        = &gate;
    end

endmodule

// File: rtl/scr_tx_path.sv
module scr_tx_path
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scr_en,
    input  addr_t phy_addr,
    input  sym_t  tx_sym_in,
    output sym_t  tx_sym_out,
    output lfsr_t lfsr_q
);

    lfsr_step_t adv;

    always_comb begin
        adv = lfsr_advance(lfsr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q     <= seed_from_addr(phy_addr);
            tx_sym_out <= '0;
        end else begin
            lfsr_q     <= adv.state;
            tx_sym_out <= scr_en ? (tx_sym_in ^ adv.ks) : tx_sym_in;
        end
    end

endmodule

// File: rtl/scr_rx_path.sv
module scr_rx_path
    import scr_pkg::*;
#(
    parameter int LOCK_RUN     = 4,
    parameter int LOCK_TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic scr_en,
    input  sym_t rx_sym_in,
    output sym_t rx_sym_out,
    output logic rx_lock
);

    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int TMO_W = $clog2(LOCK_TIMEOUT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(LOCK_TIMEOUT - 1);

    rx_state_e        st_q;
    lfsr_t            lfsr_q;
    logic [RUN_W-1:0] run_q;
    logic [TMO_W-1:0] tmo_q;
    lfsr_step_t       pred;
    sym_t             recovered;
    sym_t             plain;
    logic             hit;

    always_comb begin
        pred      = lfsr_advance(lfsr_q);
        recovered = rx_sym_in ^ IDLE_SYM;
        plain     = rx_sym_in ^ pred.ks;
        hit       = (pred.ks == recovered) && (lfsr_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= RX_HUNT;
            lfsr_q     <= '1;
            run_q      <= '0;
            tmo_q      <= '0;
            rx_sym_out <= '0;
        end else begin
            rx_sym_out <= scr_en ? plain : rx_sym_in;
            if (!scr_en) begin
                st_q   <= RX_HUNT;
                run_q  <= '0;
                tmo_q  <= '0;
                lfsr_q <= lfsr_shift_in(lfsr_q, recovered);
            end else begin
                unique case (st_q)
                    RX_HUNT: begin
                        lfsr_q <= lfsr_shift_in(lfsr_q, recovered);
                        tmo_q  <= '0;
                        if (hit) begin
                            if (run_q == RUN_LAST) begin
                                st_q  <= RX_LOCKED;
                                run_q <= '0;
                            end else begin
                                run_q <= run_q + 1'b1;
                            end
                        end else begin
                            run_q <= '0;
                        end
                    end
                    RX_LOCKED: begin
                        lfsr_q <= pred.state;
                        if (hit) begin
                            tmo_q <= '0;
                        end else if (tmo_q == TMO_LAST) begin
                            st_q  <= RX_HUNT;
                            tmo_q <= '0;
                            run_q <= '0;
                        end else begin
                            tmo_q <= tmo_q + 1'b1;
                        end
                    end
                    default: st_q <= RX_HUNT;
                endcase
            end
        end
    end

    assign rx_lock = (st_q == RX_LOCKED);

endmodule

// File: rtl/seeded_scrambler.sv
module seeded_scrambler
    import scr_pkg::*;
#(
    parameter int LOCK_RUN     = 4,
    parameter int LOCK_TIMEOUT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic             strap_scr,
    input  logic             cfg_we,
    input  logic             cfg_wdata,
    input  logic             link_100,
    input  logic             force_10,
    input  logic             line_mlt3,
    input  logic [SYM_W-1:0] tx_sym_in,
    output logic [SYM_W-1:0] tx_sym_out,
    input  logic [SYM_W-1:0] rx_sym_in,
    output logic [SYM_W-1:0] rx_sym_out,
    output logic             rx_lock
);

    logic  scr_en;
    lfsr_t tx_lfsr;

    scr_en_ctrl u_en (
        .clk       (clk),
        .rst       (rst),
        .strap_in  (strap_scr),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .link_100  (link_100),
        .force_10  (force_10),
        .line_mlt3 (line_mlt3),
        .scr_en    (scr_en)
    );

    scr_tx_path u_tx (
        .clk        (clk),
        .rst        (rst),
        .scr_en     (scr_en),
        .phy_addr   (phy_addr),
        .tx_sym_in  (tx_sym_in),
        .tx_sym_out (tx_sym_out),
        .lfsr_q     (tx_lfsr)
    );

    scr_rx_path #(
        .LOCK_RUN     (LOCK_RUN),
        .LOCK_TIMEOUT (LOCK_TIMEOUT)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .scr_en     (scr_en),
        .rx_sym_in  (rx_sym_in),
        .rx_sym_out (rx_sym_out),
        .rx_lock    (rx_lock)
    );

endmodule

// File: rtl/seeded_scrambler_chk.sv
module seeded_scrambler_chk
    import scr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  link_100,
    input logic  force_10,
    input logic  line_mlt3,
    input logic  scr_en,
    input lfsr_t tx_lfsr,
    input sym_t  tx_sym_in,
    input sym_t  tx_sym_out,
    input sym_t  rx_sym_in,
    input sym_t  rx_sym_out,
    input logic  rx_lock
);

    // Checks start only once a reset has been observed.
    logic armed = 1'b0;
    always @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    assert_seed_nonzero_R1: assert property (@(posedge clk) disable iff (rst || !armed)
        tx_lfsr != '0);

    assert_speed_bypass_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(!rst) && $past(!link_100 || force_10 || !line_mlt3))
        |-> (tx_sym_out == $past(tx_sym_in)) && (rx_sym_out == $past(rx_sym_in)));

    assert_lock_needs_enable_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(!rst) && $past(!scr_en)) |-> !rx_lock);

    assert_clean_after_reset_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(rst) |-> (!rx_lock && tx_sym_out == '0 && rx_sym_out == '0));

    assert_lock_rise_enabled_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(rx_lock) |-> $past(scr_en));

endmodule

bind seeded_scrambler seeded_scrambler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_100   (link_100),
    .force_10   (force_10),
    .line_mlt3  (line_mlt3),
    .scr_en     (scr_en),
    .tx_lfsr    (tx_lfsr),
    .tx_sym_in  (tx_sym_in),
    .tx_sym_out (tx_sym_out),
    .rx_sym_in  (rx_sym_in),
    .rx_sym_out (rx_sym_out),
    .rx_lock    (rx_lock)
);

// File: tb/seeded_scrambler_tb_top.sv
`timescale 1ns/1ps
module seeded_scrambler_tb_top;

    localparam int T_RUN = 4;
    localparam int T_TMO = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [4:0] phy_addr = '0;
    logic       strap_scr = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_wdata = 1'b1;
    logic       link_100 = 1'b1;
    logic       force_10 = 1'b0;
    logic       line_mlt3 = 1'b1;
    logic [4:0] tx_sym_in = '0;
    logic [4:0] tx_sym_out;
    logic [4:0] rx_sym_in;
    logic [4:0] rx_sym_out;
    logic       rx_lock;
    logic       loop_sel = 1'b0;
    logic [4:0] rx_drv = '0;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    logic [10:0] m;
    logic       mdl_en = 1'b1;
    logic [4:0] prev_tx = '0;
    int         rx_mode = 0;   // 0 none, 1 round trip, 2 pass-through

    always #5 clk = ~clk;

    always_comb rx_sym_in = loop_sel ? tx_sym_out : rx_drv;

    seeded_scrambler #(.LOCK_RUN(T_RUN), .LOCK_TIMEOUT(T_TMO)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .phy_addr   (phy_addr),
        .strap_scr  (strap_scr),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .link_100   (link_100),
        .force_10   (force_10),
        .line_mlt3  (line_mlt3),
        .tx_sym_in  (tx_sym_in),
        .tx_sym_out (tx_sym_out),
        .rx_sym_in  (rx_sym_in),
        .rx_sym_out (rx_sym_out),
        .rx_lock    (rx_lock)
    );

    // Generator from R2: bit = s[10]^s[8], shifted in at s[0], first bit on symbol bit 4.
    function automatic logic [15:0] mdl_adv(input logic [10:0] s);
        logic [4:0] k;
        logic       b;
        for (int i = 4; i >= 0; i--) begin
            b    = s[10] ^ s[8];
            k[i] = b;
            s    = {s[9:0], b};
        end
        return {s, k};
    endfunction

    task automatic chk(input logic ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Called at posedge+1; drives inputs, crosses one edge, checks.
    task automatic step(input logic [4:0] x, input logic [4:0] r);
        logic [15:0] a;
        logic [4:0]  exp_tx;
        logic [4:0]  rx_seen;
        tx_sym_in = x;
        rx_drv    = r;
        #1;
        rx_seen = rx_sym_in;
        a       = mdl_adv(m);
        exp_tx  = mdl_en ? (x ^ a[4:0]) : x;
        @(posedge clk);
        #1;
        chk(tx_sym_out == exp_tx, mdl_en ? "R2" : "R5", "tx_sym_out",
            int'(tx_sym_out), int'(exp_tx));
        m = a[15:5];
        if (rx_mode == 1)
            chk(rx_sym_out == prev_tx, "R7", "round trip", int'(rx_sym_out), int'(prev_tx));
        else if (rx_mode == 2)
            chk(rx_sym_out == rx_seen, "R5", "rx pass-through", int'(rx_sym_out), int'(rx_seen));
        prev_tx = x;
    endtask

    task automatic do_reset(input logic s_rise, input logic s_late, input logic [4:0] addr);
        strap_scr = s_rise;
        phy_addr  = addr;
        rst       = 1'b1;
        @(posedge clk); #1;
        strap_scr = s_late;
        @(posedge clk); #1;
        // R9: reset values
        chk(tx_sym_out == 5'd0, "R9", "tx during reset", int'(tx_sym_out), 0);
        chk(rx_sym_out == 5'd0, "R9", "rx during reset", int'(rx_sym_out), 0);
        chk(rx_lock == 1'b0, "R9", "lock during reset", int'(rx_lock), 0);
        @(posedge clk); #1;
        rst     = 1'b0;
        m       = {6'h3F, addr};   // R1 seed
        prev_tx = '0;
    endtask

    task automatic wait_lock();
        bit got = 0;
        rx_mode = 0;
        for (int i = 0; i < 30; i++) begin
            step(5'h1F, 5'h00);
            if (i == 1)
                chk(rx_lock == 1'b0, "R6", "no lock before run", int'(rx_lock), 0);
            if (rx_lock) begin
                got = 1;
                break;
            end
        end
        chk(got, "R6", "lock on idle", int'(got), 1);
    endtask

    task automatic t_keystream();
        do_reset(1'b1, 1'b1, 5'h13);
        mdl_en = 1'b1;
        for (int i = 0; i < 6; i++)  step(5'h1F, 5'h00);
        for (int i = 0; i < 6; i++)  step(5'h00, 5'h00);
        for (int i = 0; i < 32; i++) step(5'(i), 5'h00);
        for (int i = 0; i < 8; i++)  step((i % 2 == 0) ? 5'h15 : 5'h0A, 5'h00);
        do_reset(1'b1, 1'b1, 5'h00);   // R1: second seed
        for (int i = 0; i < 20; i++) step(5'(i * 7), 5'h00);
    endtask

    task automatic t_lock_roundtrip();
        do_reset(1'b1, 1'b1, 5'h0B);
        loop_sel = 1'b1;
        mdl_en   = 1'b1;
        wait_lock();
        rx_mode = 1;   // R7
        for (int i = 0; i < 40; i++) step(5'(i * 3 + 1), 5'h00);
        for (int i = 0; i < 4; i++)  step(5'h1F, 5'h00);
    endtask

    task automatic t_timeout();
        rx_mode = 1;
        for (int i = 0; i < T_TMO - 1; i++) step(5'h00, 5'h00);
        step(5'h1F, 5'h00);
        chk(rx_lock == 1'b1, "R8", "held below timeout", int'(rx_lock), 1);
        for (int i = 0; i < T_TMO; i++) step(5'h00, 5'h00);
        chk(rx_lock == 1'b1, "R8", "idle restarted count", int'(rx_lock), 1);
        step(5'h00, 5'h00);
        chk(rx_lock == 1'b0, "R8", "drop at timeout", int'(rx_lock), 0);
        rx_mode = 0;
        wait_lock();   // R6 relock
    endtask

    task automatic t_cfg_bit();
        rx_mode   = 1;
        cfg_we    = 1'b1;
        cfg_wdata = 1'b0;
        step(5'h1F, 5'h00);
        cfg_we = 1'b0;
        mdl_en = 1'b0;   // R4 write of 0
        rx_mode = 0;
        step(5'h06, 5'h00);
        chk(rx_lock == 1'b0, "R10", "lock cleared when disabled", int'(rx_lock), 0);
        rx_mode = 1;     // pass-through both ways gives round trip
        for (int i = 0; i < 6; i++) step(5'(i + 9), 5'h00);
        cfg_we    = 1'b1;
        cfg_wdata = 1'b1;
        step(5'h1F, 5'h00);
        cfg_we  = 1'b0;
        mdl_en  = 1'b1;
        rx_mode = 0;
        for (int i = 0; i < 6; i++) step(5'(i + 20), 5'h00);
        // R4: bit returns to 1 after reset
        cfg_we    = 1'b1;
        cfg_wdata = 1'b0;
        step(5'h00, 5'h00);
        cfg_we = 1'b0;
        do_reset(1'b1, 1'b1, 5'h1D);
        mdl_en = 1'b1;
        for (int i = 0; i < 8; i++) step(5'(i * 5), 5'h00);
    endtask

    task automatic t_speed();
        loop_sel = 1'b0;
        rx_mode  = 2;
        link_100 = 1'b0;
        mdl_en   = 1'b0;
        for (int i = 0; i < 6; i++) step(5'(i + 1), 5'(31 - i));
        link_100 = 1'b1;
        force_10 = 1'b1;
        for (int i = 0; i < 6; i++) step(5'(i + 11), 5'(i * 4));
        force_10  = 1'b0;
        line_mlt3 = 1'b0;
        for (int i = 0; i < 6; i++) step(5'(i * 6), 5'(i + 2));
        line_mlt3 = 1'b1;
        mdl_en    = 1'b1;
        rx_mode   = 0;
        for (int i = 0; i < 6; i++) step(5'(i + 3), 5'h00);
    endtask

    task automatic t_strap();
        loop_sel = 1'b0;
        do_reset(1'b0, 1'b1, 5'h07);   // R3: later high ignored
        mdl_en  = 1'b0;
        rx_mode = 2;
        for (int i = 0; i < 8; i++) step(5'(i * 9), 5'(i + 5));
        strap_scr = 1'b1;
        for (int i = 0; i < 4; i++) step(5'(i + 1), 5'(i));
        do_reset(1'b1, 1'b0, 5'h07);   // R3: later low ignored
        mdl_en  = 1'b1;
        rx_mode = 0;
        for (int i = 0; i < 8; i++) step(5'(i * 9), 5'h00);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        t_keystream();
        t_lock_roundtrip();
        t_timeout();
        t_cfg_bit();
        t_speed();
        t_strap();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule